// File: doc/BRIEF.md
# System control register bridge

This block is a bank of 32-bit control and status registers behind a single word-access register port. It carries three identification words, two free-running timebase counters (a slow one and a fast one, both derived from the system clock), a 16-bit lock word, a flags register with a separate clear alias, and a set of read-only constants for flash, display and oscillator settings.

It also contains an indirect configuration channel. Software first loads the config-data register and then writes a control word. If the control word's start bit is set, the block looks the packed address fields up in its table of oscillator targets. On a hit it either copies config-data into the target or loads the target's value into config-data, depending on the write bit. The transfer completes at the clock edge that accepts the control write, so status always reads complete and control always reads not busy.

Top module: `sysctl_bridge`

## Requirements
- R1: After reset, flags, lock, config-data and both counters read 0, and oscillator target i holds 25000000 + i*12500000 Hz.
- R2: A read (bus_sel=1, bus_wr=0) is captured at the clock edge and shows on bus_rdata from that edge until the next read. Offsets that are not decoded (including the flags-clear offset, 0x14) read 0.
- R3: Constant registers read fixed values: 0x00 ID_A, 0x04 ID_B, 0x08 ID_BOARD, 0x20 zero, 0x24 0x00001A00, 0x28+4*k gives 0x2C00 + k*0x111 for k in 0..4, 0x48 (status) reads 1, and 0x44 (control) reads 0. Writes to any of these leave every read value unchanged.
- R4: The slow counter (0x18) and the fast counter (0x1C) read floor(n*RATE/CLK_HZ) mod 2^32, where n is the number of clock edges since reset was released before the read edge. The rates default to 24 MHz and 100 MHz, with a 200 MHz clock.
- R5: A write to flags (0x10) loads all 32 bits. A write of any value to 0x14 clears flags to 0.
- R6: A write to lock (0x0C) keeps only wdata[15:0]. Bits 31:16 read 0.
- R7: A write to control (0x44) with bit 31 (start) clear moves no data and changes no target.
- R8: Control word fields are: bit 30 write, 29:26 dcc, 25:20 function, 17:16 site, 15:12 position, 11:0 device (bits 19:18 ignored). Oscillator target i has dcc=0, function=1, site=1, position=0, device=i. A started request that matches no target is dropped.
- R9: A matched started request with the write bit set copies config-data (0x40) into the target. With the write bit clear, it loads the target's frequency into config-data. Either result is visible to the next access.
- R10: A started write of value 0 to an oscillator target is rejected, and the target keeps its frequency.
- R11: A write to an undecoded offset changes no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one word per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in window; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every result is due one edge after its access. Read data, register updates and configuration transfers all land at the edge that accepts the access. The bench drives on the falling edge and samples bus_rdata at the next falling edge. For each read it records how many rising edges have passed since reset, which gives the exact counter values expected at the capturing edge. After each configuration request, a read of config-data or a readback request observes the outcome before any other stimulus can change it.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W = 32;

    // word indices of the decoded registers
    localparam int W_ID_A     = 0;
    localparam int W_ID_B     = 1;
    localparam int W_ID_BOARD = 2;
    localparam int W_LOCK     = 3;
    localparam int W_FLAGS    = 4;
    localparam int W_FLAGS_CLR = 5;
    localparam int W_TICK_SLOW = 6;
    localparam int W_TICK_FAST = 7;
    localparam int W_FLASH_K  = 8;
    localparam int W_DISP_K   = 9;
    localparam int W_OSCK0    = 10;
    localparam int W_CFG_DATA = 16;
    localparam int W_CFG_CTRL = 17;
    localparam int W_CFG_STAT = 18;

    localparam logic [31:0] DISP_CONST = 32'h0000_1A00;
    localparam logic [31:0] KEY_MASK   = 32'h3FF3_FFFF;
    localparam logic [5:0]  FN_OSC     = 6'd1;
    localparam logic [1:0]  OSC_SITE   = 2'd1;

    typedef struct packed {
        logic        start;
        logic        wr;
        logic [3:0]  dcc;
        logic [5:0]  func;
        logic [1:0]  spare;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cfg_ctrl_t;

    function automatic logic [31:0] osc_key(input int idx);
        cfg_ctrl_t k;
        k       = '0;
        k.func  = FN_OSC;
        k.site  = OSC_SITE;
        k.dev   = 12'(idx);
        return k;
    endfunction

    function automatic logic [31:0] osc_default(input int idx);
        return 32'(25_000_000 + idx * 12_500_000);
    endfunction

    function automatic logic [31:0] osc_const(input int idx);
        return 32'h0000_2C00 + 32'(idx) * 32'h0000_0111;
    endfunction

endpackage

// File: rtl/ref_counter.sv
module ref_counter #(
    parameter int CLK_HZ = 200_000_000,
    parameter int RATE   = 24_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam int ACC_W = $clog2(CLK_HZ) + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.acc + ACC_W'(RATE);
        if (sum >= ACC_W'(CLK_HZ)) begin
            st_d.acc = sum - ACC_W'(CLK_HZ);
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R4
    step_max_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));

endmodule

// File: rtl/cfg_engine.sv
module cfg_engine
    import sysctl_pkg::*;
#(
    parameter int NUM_OSC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_we,
    input  logic        ctrl_we,
    input  logic [31:0] wdata,
    output logic [31:0] cfg_data
);
    typedef struct packed {
        logic [31:0]                  data;
        logic [NUM_OSC-1:0][31:0]     freq;
    } eng_st_t;

    eng_st_t st_d, st_q;
    cfg_ctrl_t ctl;
    logic [NUM_OSC-1:0] hit;

    assign ctl = cfg_ctrl_t'(wdata);

    generate
        for (genvar g = 0; g < NUM_OSC; g++) begin : g_match
            assign hit[g] = ctrl_we && ctl.start &&
                            ((wdata & KEY_MASK) == osc_key(g));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (data_we) st_d.data = wdata;
        for (int i = 0; i < NUM_OSC; i++) begin
            if (hit[i]) begin
                if (ctl.wr) begin
                    if (st_q.data != '0) st_d.freq[i] = st_q.data;
                end else begin
                    st_d.data = st_q.freq[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data <= '0;
            for (int i = 0; i < NUM_OSC; i++) st_q.freq[i] <= osc_default(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_data = st_q.data;

    // R8
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R7
    idle_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && !wdata[31]) |=> $stable(cfg_data) && $stable(st_q.freq));

    generate
        for (genvar g = 0; g < NUM_OSC; g++) begin : g_chk
            // R10
            zero_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[g] && wdata[30] && cfg_data == '0) |=> $stable(st_q.freq[g]));
            // R9
            read_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[g] && !wdata[30]) |=> cfg_data == $past(st_q.freq[g]));
        end
    endgenerate

endmodule

// File: rtl/sysctl_bridge.sv
module sysctl_bridge
    import sysctl_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          CLK_HZ   = 200_000_000,
    parameter int          SLOW_HZ  = 24_000_000,
    parameter int          FAST_HZ  = 100_000_000,
    parameter int          NUM_OSC  = 3,
    parameter int          NUM_OSCK = 5,
    parameter logic [31:0] ID_A     = 32'h0C00_0191,
    parameter logic [31:0] ID_B     = 32'h0C10_0302,
    parameter logic [31:0] ID_BOARD = 32'h1190_0F20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int OSCK_END = W_OSCK0 + NUM_OSCK;

    typedef struct packed {
        logic [31:0] flags;
        logic [15:0] lock;
        logic [31:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    int          widx;
    logic        wr_acc, rd_acc;
    logic [31:0] rd_val;
    logic [31:0] tick_slow, tick_fast, cfg_data;

    assign widx   = int'({{(32 - ADDR_W){1'b0}}, bus_addr} >> 2);
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    ref_counter #(.CLK_HZ(CLK_HZ), .RATE(SLOW_HZ), .CNT_W(32)) u_slow (
        .clk(clk), .rst_n(rst_n), .count(tick_slow));

    ref_counter #(.CLK_HZ(CLK_HZ), .RATE(FAST_HZ), .CNT_W(32)) u_fast (
        .clk(clk), .rst_n(rst_n), .count(tick_fast));

    cfg_engine #(.NUM_OSC(NUM_OSC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (wr_acc && widx == W_CFG_DATA),
        .ctrl_we (wr_acc && widx == W_CFG_CTRL),
        .wdata   (bus_wdata),
        .cfg_data(cfg_data)
    );

    always_comb begin
        rd_val = '0;
        case (widx)
            W_ID_A:      rd_val = ID_A;
            W_ID_B:      rd_val = ID_B;
            W_ID_BOARD:  rd_val = ID_BOARD;
            W_LOCK:      rd_val = {16'h0000, st_q.lock};
            W_FLAGS:     rd_val = st_q.flags;
            W_TICK_SLOW: rd_val = tick_slow;
            W_TICK_FAST: rd_val = tick_fast;
            W_DISP_K:    rd_val = DISP_CONST;
            W_CFG_DATA:  rd_val = cfg_data;
            W_CFG_STAT:  rd_val = 32'd1;
            default: begin
                if (widx >= W_OSCK0 && widx < OSCK_END)
                    rd_val = osc_const(widx - W_OSCK0);
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_acc) begin
            case (widx)
                W_FLAGS:     st_d.flags = bus_wdata;
                W_FLAGS_CLR: st_d.flags = '0;
                W_LOCK:      st_d.lock  = bus_wdata[15:0];
                default:     ;
            endcase
        end
        if (rd_acc) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R5
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && widx == W_FLAGS_CLR) |=> st_q.flags == '0);

    // R6
    lock_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && widx == W_LOCK) |=> st_q.lock == $past(bus_wdata[15:0]));

    // R3
    status_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && widx == W_CFG_STAT) |=> bus_rdata == 32'd1);

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(bus_rdata));

endmodule

// File: tb/sysctl_bridge_test.sv
module sysctl_bridge_test;

    localparam int          ADDR_W   = 8;
    localparam int          CLK_HZ   = 200_000_000;
    localparam int          SLOW_HZ  = 24_000_000;
    localparam int          FAST_HZ  = 100_000_000;
    localparam int          NUM_OSC  = 3;
    localparam int          NUM_OSCK = 5;
    localparam logic [31:0] ID_A     = 32'hA1A1_0001;
    localparam logic [31:0] ID_B     = 32'hB2B2_0002;
    localparam logic [31:0] ID_BOARD = 32'hC3C3_0003;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;

    int total = 0;
    int bad = 0;
    longint unsigned cyc = 0;

    logic [31:0] m_flags, m_data;
    logic [15:0] m_lock;
    logic [31:0] m_freq [NUM_OSC];

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    sysctl_bridge #(
        .ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ),
        .NUM_OSC(NUM_OSC), .NUM_OSCK(NUM_OSCK),
        .ID_A(ID_A), .ID_B(ID_B), .ID_BOARD(ID_BOARD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] mk_ctrl(input logic st, input logic w,
            input int dcc, input int fn, input int site, input int pos, input int dev);
        return {st, w, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
    endfunction

    function automatic string req_of(input int w);
        if (w == 3) return "R6";
        if (w == 4 || w == 5) return "R5";
        if (w == 6 || w == 7) return "R4";
        if (w == 16) return "R9";
        if (w <= 2 || (w >= 8 && w <= 14) || w == 17 || w == 18) return "R3";
        return "R2";
    endfunction

    function automatic logic [31:0] exp_read(input int w, input longint unsigned c);
        case (w)
            0: return ID_A;
            1: return ID_B;
            2: return ID_BOARD;
            3: return {16'h0, m_lock};
            4: return m_flags;
            6: return 32'((c * longint'(SLOW_HZ)) / longint'(CLK_HZ));
            7: return 32'((c * longint'(FAST_HZ)) / longint'(CLK_HZ));
            9: return 32'h0000_1A00;
            16: return m_data;
            18: return 32'd1;
            default: begin
                if (w >= 10 && w < 10 + NUM_OSCK)
                    return 32'h2C00 + 32'(w - 10) * 32'h111;
                return 32'h0;
            end
        endcase
    endfunction

    task automatic model_write(input int w, input logic [31:0] d);
        case (w)
            3: m_lock = d[15:0];
            4: m_flags = d;
            5: m_flags = '0;
            16: m_data = d;
            17: begin
                if (d[31]) begin
                    for (int i = 0; i < NUM_OSC; i++) begin
                        if ((d & 32'h3FF3_FFFF) == mk_ctrl(0, 0, 0, 1, 1, 0, i)) begin
                            if (d[30]) begin
                                if (m_data != 0) m_freq[i] = m_data;
                            end else begin
                                m_data = m_freq[i];
                            end
                        end
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic wr(input int w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = ADDR_W'(w * 4); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        model_write(w, d);
    endtask

    task automatic rd(input int w, input string tag);
        longint unsigned c;
        logic [31:0] e;
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = ADDR_W'(w * 4) | ADDR_W'($urandom_range(0, 3));
        c = cyc;
        e = exp_read(w, c);
        @(negedge clk);
        bus_sel = 1'b0;
        total++;
        if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s word %0d: got %h want %h", tag, w, bus_rdata, e);
        end
    endtask

    task automatic osc_read_check(input int i, input string tag);
        wr(17, mk_ctrl(1, 0, 0, 1, 1, 0, i));
        rd(16, tag);
    endtask

    initial begin
        #(5ns * 150000);
        bad++;
        $display("FAIL watchdog: got timeout want completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'd9071);
        m_flags = '0; m_lock = '0; m_data = '0;
        for (int i = 0; i < NUM_OSC; i++) m_freq[i] = 32'(25_000_000 + i * 12_500_000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4, "R1"); rd(3, "R1"); rd(16, "R1"); rd(6, "R1"); rd(7, "R1");
        for (int i = 0; i < NUM_OSC; i++) osc_read_check(i, "R1");

        // R3 constants, writes ignored
        for (int w = 0; w <= 18; w++) rd(w, req_of(w));
        wr(0, 32'hFFFF_FFFF); wr(9, 32'h1234_5678); wr(11, 32'h0); wr(18, 32'h0);
        wr(8, 32'hDEAD_BEEF);
        for (int w = 0; w <= 18; w++) if (w != 5) rd(w, "R3");

        // R5 flags load and clear
        wr(4, 32'hCAFE_F00D); rd(4, "R5");
        wr(5, 32'h0);         rd(4, "R5");
        wr(4, 32'h0000_0001); wr(5, 32'hFFFF_FFFF); rd(4, "R5");

        // R6 lock keeps low half
        wr(3, 32'hABCD_1234); rd(3, "R6");

        // R11 undecoded writes
        wr(4, 32'h5555_AAAA);
        wr(30, 32'hFFFF_FFFF); wr(63, 32'h1); wr(19, 32'h7);
        rd(4, "R11"); rd(30, "R11"); rd(3, "R11"); rd(16, "R11");

        // R9 write then read back
        wr(16, 32'd33_000_000); wr(17, mk_ctrl(1, 1, 0, 1, 1, 0, 2));
        wr(16, 32'h0); osc_read_check(2, "R9");
        // R7 no start
        wr(16, 32'd77); wr(17, mk_ctrl(0, 1, 0, 1, 1, 0, 0)); rd(16, "R7");
        wr(17, mk_ctrl(0, 0, 0, 1, 1, 0, 0)); rd(16, "R7");
        osc_read_check(0, "R7");
        // R8 mismatched fields dropped
        wr(16, 32'd11);
        wr(17, mk_ctrl(1, 0, 1, 1, 1, 0, 0)); rd(16, "R8");
        wr(17, mk_ctrl(1, 0, 0, 2, 1, 0, 0)); rd(16, "R8");
        wr(17, mk_ctrl(1, 0, 0, 1, 2, 0, 0)); rd(16, "R8");
        wr(17, mk_ctrl(1, 0, 0, 1, 1, 3, 0)); rd(16, "R8");
        wr(17, mk_ctrl(1, 0, 0, 1, 1, 0, NUM_OSC)); rd(16, "R8");
        wr(17, mk_ctrl(1, 1, 0, 1, 1, 0, 9)); osc_read_check(1, "R8");
        wr(17, mk_ctrl(1, 0, 0, 1, 1, 0, 1) | 32'h000C_0000); rd(16, "R8");
        // R10 zero rejected
        wr(16, 32'h0); wr(17, mk_ctrl(1, 1, 0, 1, 1, 0, 1)); osc_read_check(1, "R10");

        // R4 counters after idle gaps
        repeat (37) @(negedge clk);
        rd(6, "R4"); rd(7, "R4");
        repeat (1000) @(negedge clk);
        rd(6, "R4"); rd(7, "R4");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op, w;
            op = int'($urandom_range(0, 9));
            w  = int'($urandom_range(0, 63));
            case (op)
                0, 1, 2: rd(w, req_of(w));
                3: wr(w, $urandom());
                4: wr(4, $urandom());
                5: wr(5, $urandom());
                6: wr(3, $urandom());
                7: wr(16, ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom());
                8: wr(17, mk_ctrl(1, $urandom_range(0, 1), 0, 1, 1, 0,
                                  int'($urandom_range(0, NUM_OSC))));
                default: osc_read_check(int'($urandom_range(0, NUM_OSC - 1)), "R9");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule